// File: doc/BRIEF.md
# NAND Bad-Block Scan Engine

After power-up, and before any program or erase is allowed, this engine walks every erase block of a NAND array and records which blocks carry a factory bad marker. The marker is the first byte of a page's spare area. For each block the engine reads that byte on page 0. When page 0 reads as the erased value FFh, it also reads the byte on page 1. If any byte it reads differs from FFh, the block is recorded as bad. Block 0 is the boot block, so it is always recorded as good.

Each read goes through a simple byte-read port that allows one request at a time. The result is stored in a one-bit-per-block map. A host can query the map at any time by block index. When the walk ends, the engine gives a one-cycle done pulse and holds a bad-block count. It also holds a flag that is raised when there are more bad blocks than the device may have.

The controller is a five-state machine:
- **IDLE**: waits for `start`.
- **ISSUE**: raises `rd_req` for one cycle.
- **WAIT**: holds the address until `rd_valid` arrives.
- **RECORD**: writes the map entry and the count.
- **DONE**: pulses `done` for one cycle.

Its transitions are:
- **IDLE→ISSUE** on `start`. This also clears the map and the count, and selects block 0, page 0.
- **ISSUE→WAIT** always.
- **WAIT→ISSUE** on a valid FFh byte from page 0. The next read is page 1 of the same block.
- **WAIT→RECORD** on a valid byte that is not FFh, or on any valid byte from page 1.
- **RECORD→ISSUE** to move to the next block, at page 0.
- **RECORD→DONE** after the last block.
- **DONE→IDLE** always.

Top module: `nand_bbt_scanner`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `rd_req` and `too_many_bad` are 0, `bad_count` is 0, and every map entry reads 0 (good).
- R2: A `start` pulse while idle clears every map entry and the count. From the next cycle, `busy` is 1 and `bad_count` is 0.
- R3: Every read is a one-cycle `rd_req` with `rd_col` equal to 2048. `rd_block` and `rd_page` hold their values in the following cycle. No new request is made before `rd_valid` returns for the current one.
- R4: Blocks are read in ascending order from 0 to 4095. Page 0 is read first (`rd_page`=0). Page 1 (`rd_page`=1) of the same block is read only when the page 0 byte was FFh.
- R5: A block other than 0 is bad when any marker byte read for it differs from FFh. Its map entry, seen on `q_bad` for `q_block`, is then 1; otherwise it is 0.
- R6: The map entry for block 0 reads 0 and block 0 is not counted, whatever its markers hold.
- R7: When the scan ends, `bad_count` equals the number of map entries that read 1.
- R8: `too_many_bad` is 1 exactly when `bad_count` exceeds 80 (fewer than 4016 good blocks). A count of exactly 80 leaves it at 0.
- R9: After the last block is recorded, `done` is high for exactly one cycle. In that cycle `busy` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| rd_req | output | 1 | One-cycle byte-read request |
| rd_block | output | 12 | Block index of the read |
| rd_page | output | 1 | Page within the block (0 or 1) |
| rd_col | output | 12 | Column of the read (marker column) |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Byte returned by the array |
| q_block | input | 12 | Map query index |
| q_bad | output | 1 | Map entry for `q_block`, 1 = bad |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| bad_count | output | 13 | Number of bad blocks recorded |
| too_many_bad | output | 1 | Bad count above the allowed limit |

## Verification
The engine is run through three marker patterns:
- **Random spread.** Random non-FFh values are placed on either page of about sixty blocks, and block 0 is marked on page 0. This separates page-0 hits, which skip the page 1 read, from page-1 hits, which cost a second read. It also shows that block 0 is excluded.
- **Exactly 80 bad blocks.** This pattern, with block 0 marked on page 1, shows that the limit is not crossed at 80.
- **81 bad blocks.** The extra mark is on the last block. It shows that the flag rises on the first block over the limit, and that the final block is both read and recorded.

Between runs, the first cycles of a new scan show that the previous map and count were cleared. Every read request is compared with an ordered list of expected block and page reads, built from the preloaded markers.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RECORD,
        ST_DONE
    } scan_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nbb_scan_ctrl.sv
module nbb_scan_ctrl
    import nbb_pkg::*;
#(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_valid,
    input  logic [7:0]       rd_data,
    output logic             rd_req,
    output logic [BLK_W-1:0] rd_block,
    output logic             rd_page,
    output logic             busy,
    output logic             done,
    output logic             clr,
    output logic             rec_we,
    output logic [BLK_W-1:0] rec_block,
    output logic             rec_bad
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic             page_q;
    logic             hit_q;
    logic             byte_hit;

    assign byte_hit = (rd_data != ERASED_BYTE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    if (byte_hit || page_q) state_d = ST_RECORD;
                    else                    state_d = ST_ISSUE;
                end
            end
            ST_RECORD: state_d = (blk_q == LAST_BLK) ? ST_DONE : ST_ISSUE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // block, page and marker datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            page_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        blk_q  <= '0;
                        page_q <= 1'b0;
                        hit_q  <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        hit_q <= byte_hit;
                        if (!byte_hit && !page_q) page_q <= 1'b1;
                    end
                end
                ST_RECORD: begin
                    page_q <= 1'b0;
                    if (blk_q != LAST_BLK) blk_q <= blk_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req    = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        clr       = 1'b0;
        rec_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:   clr = start;
            ST_ISSUE: begin
                rd_req = 1'b1;
                busy   = 1'b1;
            end
            ST_WAIT:   busy = 1'b1;
            ST_RECORD: begin
                busy   = 1'b1;
                rec_we = 1'b1;
            end
            ST_DONE:   done = 1'b1;
            default: ;
        endcase
    end

    assign rd_block  = blk_q;
    assign rd_page   = page_q;
    assign rec_block = blk_q;
    assign rec_bad   = hit_q && (blk_q != '0);

endmodule

// File: rtl/nbb_block_map.sv
module nbb_block_map #(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bad
);

    logic [NUM_BLOCKS-1:0] map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      map_q <= '0;
        else if (clr)    map_q <= '0;
        else if (we)     map_q[wr_idx] <= wr_bad;
    end

    assign rd_bad = map_q[rd_idx];

endmodule

// File: rtl/nbb_bad_tally.sv
module nbb_bad_tally #(
    parameter int CNT_W   = 13,
    parameter int MAX_BAD = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             over
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign over  = (cnt_q > CNT_W'(MAX_BAD));

endmodule

// File: rtl/nand_bbt_scanner.sv
module nand_bbt_scanner #(
    parameter int NUM_BLOCKS = 4096,
    parameter int MIN_GOOD   = 4016,
    parameter int MARK_COL   = 2048,
    parameter int COL_W      = 12,
    parameter int BLK_W      = $clog2(NUM_BLOCKS),
    parameter int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_req,
    output logic [BLK_W-1:0] rd_block,
    output logic             rd_page,
    output logic [COL_W-1:0] rd_col,
    input  logic             rd_valid,
    input  logic [7:0]       rd_data,
    input  logic [BLK_W-1:0] q_block,
    output logic             q_bad,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bad_count,
    output logic             too_many_bad
);

    localparam int MAX_BAD = NUM_BLOCKS - MIN_GOOD;

    logic             clr;
    logic             rec_we;
    logic [BLK_W-1:0] rec_block;
    logic             rec_bad;

    assign rd_col = COL_W'(MARK_COL);

    nbb_scan_ctrl #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_block  (rd_block),
        .rd_page   (rd_page),
        .busy      (busy),
        .done      (done),
        .clr       (clr),
        .rec_we    (rec_we),
        .rec_block (rec_block),
        .rec_bad   (rec_bad)
    );

    nbb_block_map #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .we     (rec_we),
        .wr_idx (rec_block),
        .wr_bad (rec_bad),
        .rd_idx (q_block),
        .rd_bad (q_bad)
    );

    nbb_bad_tally #(
        .CNT_W   (CNT_W),
        .MAX_BAD (MAX_BAD)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (rec_we && rec_bad),
        .count (bad_count),
        .over  (too_many_bad)
    );

endmodule

// File: rtl/nbb_scan_checker.sv
module nbb_scan_checker #(
    parameter int BLK_W    = 12,
    parameter int COL_W    = 12,
    parameter int CNT_W    = 13,
    parameter int MARK_COL = 2048,
    parameter int NUM_BLOCKS = 4096
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_req,
    input logic [BLK_W-1:0] rd_block,
    input logic             rd_page,
    input logic [COL_W-1:0] rd_col,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bad_count
);

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ($stable(rd_block) && $stable(rd_page)));

    assert_mark_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_col == COL_W'(MARK_COL)));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy && bad_count == '0));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count <= CNT_W'(NUM_BLOCKS - 1));

endmodule

bind nand_bbt_scanner nbb_scan_checker #(
    .BLK_W      (BLK_W),
    .COL_W      (COL_W),
    .CNT_W      (CNT_W),
    .MARK_COL   (MARK_COL),
    .NUM_BLOCKS (NUM_BLOCKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_req    (rd_req),
    .rd_block  (rd_block),
    .rd_page   (rd_page),
    .rd_col    (rd_col),
    .busy      (busy),
    .done      (done),
    .bad_count (bad_count)
);

// File: tb/nand_bbt_scanner_test.sv
module nand_bbt_scanner_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4096;
    localparam int LIMIT      = 80;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req;
    logic [11:0] rd_block;
    logic        rd_page;
    logic [11:0] rd_col;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [11:0] q_block = '0;
    logic        q_bad;
    logic        busy;
    logic        done;
    logic [12:0] bad_count;
    logic        too_many_bad;

    nand_bbt_scanner uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rd_req       (rd_req),
        .rd_block     (rd_block),
        .rd_page      (rd_page),
        .rd_col       (rd_col),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .q_block      (q_block),
        .q_bad        (q_bad),
        .busy         (busy),
        .done         (done),
        .bad_count    (bad_count),
        .too_many_bad (too_many_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] mark0 [NB];
    logic [7:0] mark1 [NB];
    bit         exp_bad [NB];
    int         exp_cnt;
    int         exp_q[$];
    int         n_checks = 0;
    int         n_fail   = 0;
    int         cycles   = 0;
    logic [31:0] lcg = 32'h1234_5678;

    bit         pend = 1'b0;
    int         pend_blk;
    bit         pend_pg;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog", cycles, WATCHDOG);
            finish_run();
        end
    end

    // array model with one-cycle response and per-clock request comparison (R3, R4)
    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (pend) begin
            rd_valid = 1'b1;
            rd_data  = pend_pg ? mark1[pend_blk] : mark0[pend_blk];
            pend     = 1'b0;
        end
        if (rd_req) begin
            int got;
            got = int'(rd_block) * 2 + int'(rd_page);
            check(rd_col == 12'd2048, "R3 column", int'(rd_col), 2048);
            check(!pend && !rd_valid, "R3 single outstanding", 1, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected read", got, -1);
            end else begin
                int want;
                want = exp_q.pop_front();
                check(got == want, "R4 read order (block*2+page)", got, want);
            end
            pend     = 1'b1;
            pend_blk = int'(rd_block);
            pend_pg  = rd_page;
        end
    end

    function automatic logic [7:0] rand_mark();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return (lcg[23:16] == 8'hFF) ? 8'h00 : lcg[23:16];
    endfunction

    task automatic clear_marks();
        for (int b = 0; b < NB; b++) begin
            mark0[b] = 8'hFF;
            mark1[b] = 8'hFF;
        end
    endtask

    task automatic build_model();
        exp_q.delete();
        exp_cnt = 0;
        for (int b = 0; b < NB; b++) begin
            exp_q.push_back(b * 2);
            if (mark0[b] == 8'hFF) exp_q.push_back(b * 2 + 1);
            exp_bad[b] = (b != 0) && (mark0[b] != 8'hFF || mark1[b] != 8'hFF);
            if (exp_bad[b]) exp_cnt++;
        end
    endtask

    task automatic run_scan(input int stale_blk);
        build_model();
        @(negedge clk);
        #1;
        start = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(bad_count == 13'd0, "R2 count cleared", int'(bad_count), 0);
        if (stale_blk >= 0) begin
            q_block = 12'(stale_blk);
            #1;
            check(q_bad == 1'b0, "R2 map cleared", int'(q_bad), 0);
        end
        while (!done) begin
            @(negedge clk);
            #1;
            if (!done) check(busy == 1'b1, "R9 busy during scan", int'(busy), 1);
        end
        check(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        check(int'(bad_count) == exp_cnt, "R7 bad count", int'(bad_count), exp_cnt);
        check(too_many_bad == (exp_cnt > LIMIT), "R8 limit flag",
              int'(too_many_bad), int'(exp_cnt > LIMIT));
        check(exp_q.size() == 0, "R4 all reads issued", exp_q.size(), 0);
        @(negedge clk);
        #1;
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
        for (int b = 0; b < NB; b++) begin
            q_block = 12'(b);
            #1;
            if (b == 0) check(q_bad == 1'b0, "R6 block 0 good", int'(q_bad), 0);
            else        check(q_bad == exp_bad[b], "R5 map entry", int'(q_bad), int'(exp_bad[b]));
        end
    endtask

    int stale;

    initial begin
        clear_marks();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0 && rd_req == 1'b0, "R1 idle outputs", int'(busy), 0);
        check(bad_count == 13'd0, "R1 count", int'(bad_count), 0);
        check(too_many_bad == 1'b0, "R1 limit flag", int'(too_many_bad), 0);
        q_block = 12'd77;
        #1;
        check(q_bad == 1'b0, "R1 map empty", int'(q_bad), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Pattern A: random spread, block 0 marked on page 0
        clear_marks();
        mark0[0] = 8'h00;
        for (int i = 0; i < 60; i++) begin
            int b;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            b = 1 + int'(lcg[27:16]) % (NB - 1);
            if (lcg[5]) mark1[b] = rand_mark();
            else        mark0[b] = rand_mark();
            if (i % 7 == 0) mark1[b] = rand_mark();
        end
        run_scan(-1);
        stale = -1;
        for (int b = 1; b < NB; b++) begin
            if (exp_bad[b] && (b % 10 != 0 || b > 800) && stale < 0) stale = b;
        end

        // Pattern B: exactly the limit, block 0 marked on page 1
        clear_marks();
        mark1[0] = 8'h5A;
        for (int i = 1; i <= LIMIT; i++) begin
            if (i % 2 == 0) mark0[i * 10] = 8'hFE;
            else            mark1[i * 10] = 8'h7F;
        end
        run_scan(stale);

        // Pattern C: one over the limit, extra mark on the last block's page 1
        mark1[NB - 1] = 8'h00;
        run_scan(-1);

        finish_run();
    end

endmodule